// File: doc/BRIEF.md
# I2C SCL Clock Generator with Stretch-Aware Data Setup

This block produces the serial clock for an I2C master in standard and fast modes. A 16-bit baud count sets the length of one clock phase, counted in input clock cycles. In standard mode the low and high halves of SCL each last one baud count. In fast mode the low half lasts two baud counts and the high half lasts one. A 2-bit speed code selects the mode. Only one code selects fast timing, and every other code falls back to standard timing. Software derives the baud count as the input clock divided by the SCL rate times the divider, where the divider is 2 for standard mode and 3 for fast mode.

The block drives SCL low through an open-drain style enable and watches the sampled line. While it has released SCL but the line still reads low, a target is stretching the clock, so the high-phase counter holds. When the line is seen high again after a stretch, a setup counter loads a programmable number of input clock cycles. The next data-change strobe waits until that counter has run out. The sequencer gets two single-cycle strobes: one that says SDA may change (once per low phase) and one that says SDA may be sampled (just after SCL is seen high). A baud count of zero parks the clock with SCL released, and the clock does not start while the line is held low.

Top module: `scl_baud_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the drive output is 0 (SCL released) and both strobes are 0.
- R2: With speed code 0 and baud count B, SCL is driven low for exactly B cycles, then released for exactly B cycles (no stretch).
- R3: With speed code 1 (fast) and baud count B, SCL is driven low for 2·B cycles, then released for B cycles.
- R4: Speed codes 2 and 3 produce the same timing as code 0: low B cycles, high B cycles.
- R5: A baud count of 0 stops the clock at the end of the current phase. SCL then stays released and no strobe is produced. Writing a nonzero count restarts the clock.
- R6: While the drive output is 0 and the sampled line reads low, the drive stays 0 and the high-phase count is frozen. A stretch of H cycles lengthens the released phase to B+H cycles.
- R7: The sample strobe is a one-cycle pulse in the cycle right after the first cycle of a released phase in which the line reads high. Without a stretch, this is the second cycle of the released phase.
- R8: The change strobe is a one-cycle pulse. With no setup delay pending, it appears in the second cycle of each low phase.
- R9: After a stretch ends, a setup count S is loaded on the first high cycle. The change strobe of the following low phase then appears max(1, S−B+2) cycles after that low phase begins.
- R10: From the parked state, the clock starts only when the sampled line reads high. A nonzero baud count with the line held low leaves SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_cnt_i | input | 16 | Phase length in input clock cycles; 0 parks the clock |
| speed_mode_i | input | 2 | Speed code: 1 is fast, any other code is standard |
| setup_cnt_i | input | 16 | Data setup delay after a stretch, in input clock cycles |
| scl_in_i | input | 1 | Sampled SCL line level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| smp_tick_o | output | 1 | One-cycle strobe: SDA may be sampled |
| chg_tick_o | output | 1 | One-cycle strobe: SDA may change |

## Verification
The bench measures phase lengths for every speed code, including the reserved codes 2 and 3 and a baud count of 1. A design that ignored the fallback, or that was off by one on the counter load, would show the wrong low or high duration. It holds the line low for several cycles at the start of a released phase. A design that kept counting would end the high phase early, and one that ignored the setup count would fire the change strobe in the second low cycle instead of the delayed one. It also parks the clock with a zero count and tries to restart it while the line is held low. A design that drove SCL anyway, or kept emitting strobes while parked, would be caught.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int SPEED_W = 2;
  localparam logic [SPEED_W-1:0] SPD_FAST = 2'd1;

  // Only the fast code splits the period in three; every other code is standard.
  function automatic logic three_phase(input logic [SPEED_W-1:0] code);
    return code == SPD_FAST;
  endfunction

endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len
  import scl_timer_pkg::*;
#(
  parameter int BAUD_W = 16,
  parameter int LOW_MULT_FAST = 2,
  localparam int LEN_W = BAUD_W + 1
) (
  input  logic [SPEED_W-1:0] speed_mode_i,
  input  logic [BAUD_W-1:0]  baud_i,
  output logic [LEN_W-1:0]   low_len_o,
  output logic [LEN_W-1:0]   high_len_o
);

  logic [LEN_W-1:0] baud_ext;
  logic [LEN_W-1:0] fast_low;

  assign baud_ext = {1'b0, baud_i};

  generate
    if (LOW_MULT_FAST == 2) begin : g_shift
      assign fast_low = {baud_i, 1'b0};
    end else begin : g_mult
      assign fast_low = LEN_W'(baud_ext * LEN_W'(LOW_MULT_FAST));
    end
  endgenerate

  always_comb begin
    high_len_o = baud_ext;
    low_len_o  = three_phase(speed_mode_i) ? fast_low : baud_ext;
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timer_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  input  logic             scl_in_i,
  output logic             scl_low_o,
  output logic             smp_tick_o,
  output logic             enter_low_o,
  output logic             stretch_end_o,
  output logic             idle_o
);

  phase_e           phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic             armed_q;
  logic             stretched_q;
  logic             hi_seen;
  logic             cnt_zero;

  always_comb begin
    cnt_zero      = (cnt_q == '0);
    hi_seen       = (phase_q == PH_HIGH) && armed_q && scl_in_i;
    stretch_end_o = hi_seen && stretched_q;
    idle_o        = (phase_q == PH_IDLE);
    enter_low_o   = run_i && scl_in_i &&
                    ((phase_q == PH_IDLE) || ((phase_q == PH_HIGH) && cnt_zero));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      scl_low_o   <= 1'b0;
      smp_tick_o  <= 1'b0;
      armed_q     <= 1'b0;
      stretched_q <= 1'b0;
    end else begin
      smp_tick_o <= hi_seen;
      unique case (phase_q)
        PH_IDLE: begin
          if (enter_low_o) begin
            phase_q   <= PH_LOW;
            cnt_q     <= low_len_i - 1'b1;
            scl_low_o <= 1'b1;
          end
        end
        PH_LOW: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (run_i) begin
            phase_q     <= PH_HIGH;
            cnt_q       <= high_len_i - 1'b1;
            scl_low_o   <= 1'b0;
            armed_q     <= 1'b1;
            stretched_q <= 1'b0;
          end else begin
            phase_q   <= PH_IDLE;
            scl_low_o <= 1'b0;
          end
        end
        PH_HIGH: begin
          if (!scl_in_i) begin
            stretched_q <= 1'b1;
          end else begin
            armed_q     <= 1'b0;
            stretched_q <= 1'b0;
            if (!cnt_zero) begin
              cnt_q <= cnt_q - 1'b1;
            end else if (run_i) begin
              phase_q   <= PH_LOW;
              cnt_q     <= low_len_i - 1'b1;
              scl_low_o <= 1'b1;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
        end
        default: begin
          phase_q   <= PH_IDLE;
          scl_low_o <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/scl_setup_gate.sv
module scl_setup_gate #(
  parameter int SETUP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               idle_i,
  input  logic               enter_low_i,
  input  logic               stretch_end_i,
  input  logic [SETUP_W-1:0] setup_i,
  output logic               chg_tick_o
);

  logic [SETUP_W-1:0] su_q;
  logic               pend_q;
  logic               su_done;

  assign su_done = (su_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      su_q       <= '0;
      pend_q     <= 1'b0;
      chg_tick_o <= 1'b0;
    end else begin
      chg_tick_o <= pend_q && su_done;
      if (stretch_end_i) begin
        su_q <= setup_i;
      end else if (!su_done) begin
        su_q <= su_q - 1'b1;
      end
      if (enter_low_i) begin
        pend_q <= 1'b1;
      end else begin
        pend_q <= pend_q && !su_done && !idle_i;
      end
    end
  end

endmodule

// File: rtl/scl_baud_timer.sv
module scl_baud_timer
  import scl_timer_pkg::*;
#(
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BAUD_W-1:0]  baud_cnt_i,
  input  logic [1:0]         speed_mode_i,
  input  logic [SETUP_W-1:0] setup_cnt_i,
  input  logic               scl_in_i,
  output logic               scl_low_o,
  output logic               smp_tick_o,
  output logic               chg_tick_o
);

  localparam int LEN_W = BAUD_W + 1;

  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] high_len;
  logic             run;
  logic             enter_low;
  logic             stretch_end;
  logic             idle;

  assign run = (baud_cnt_i != '0);

  scl_phase_len #(.BAUD_W(BAUD_W)) u_len (
    .speed_mode_i (speed_mode_i),
    .baud_i       (baud_cnt_i),
    .low_len_o    (low_len),
    .high_len_o   (high_len)
  );

  scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .run_i         (run),
    .low_len_i     (low_len),
    .high_len_i    (high_len),
    .scl_in_i      (scl_in_i),
    .scl_low_o     (scl_low_o),
    .smp_tick_o    (smp_tick_o),
    .enter_low_o   (enter_low),
    .stretch_end_o (stretch_end),
    .idle_o        (idle)
  );

  scl_setup_gate #(.SETUP_W(SETUP_W)) u_setup (
    .clk           (clk),
    .rst           (rst),
    .idle_i        (idle),
    .enter_low_i   (enter_low),
    .stretch_end_i (stretch_end),
    .setup_i       (setup_cnt_i),
    .chg_tick_o    (chg_tick_o)
  );

endmodule

// File: rtl/scl_baud_timer_chk.sv
module scl_baud_timer_chk #(
  parameter int BAUD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [BAUD_W-1:0] baud_cnt_i,
  input logic              scl_in_i,
  input logic              scl_low_o,
  input logic              smp_tick_o,
  input logic              chg_tick_o
);

  a_r1_reset_released: assert property (@(posedge clk)
    rst |=> (!scl_low_o && !smp_tick_o && !chg_tick_o));

  a_r5_zero_baud_no_drive: assert property (@(posedge clk) disable iff (rst)
    (baud_cnt_i == '0 && !scl_low_o) |=> !scl_low_o);

  // Covers R6 (stretch) and R10 (no start while held low).
  a_r6_stretch_keeps_release: assert property (@(posedge clk) disable iff (rst)
    (!scl_low_o && !scl_in_i) |=> !scl_low_o);

  a_r7_smp_after_high: assert property (@(posedge clk) disable iff (rst)
    smp_tick_o |-> $past(!scl_low_o && scl_in_i));

  a_r7_smp_single: assert property (@(posedge clk) disable iff (rst)
    smp_tick_o |=> !smp_tick_o);

  a_r8_chg_single: assert property (@(posedge clk) disable iff (rst)
    chg_tick_o |=> !chg_tick_o);

endmodule

bind scl_baud_timer scl_baud_timer_chk #(.BAUD_W(BAUD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .baud_cnt_i (baud_cnt_i),
  .scl_in_i   (scl_in_i),
  .scl_low_o  (scl_low_o),
  .smp_tick_o (smp_tick_o),
  .chg_tick_o (chg_tick_o)
);

// File: tb/scl_baud_timer_test.sv
`timescale 1ns/1ps
module scl_baud_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] baud = '0;
  logic [1:0]  mode = '0;
  logic [15:0] setup = '0;
  logic        hold = 1'b0;
  logic        scl_in;
  logic        scl_low, smp_tick, chg_tick;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  assign scl_in = !scl_low && !hold;

  scl_baud_timer uut (
    .clk          (clk),
    .rst          (rst),
    .baud_cnt_i   (baud),
    .speed_mode_i (mode),
    .setup_cnt_i  (setup),
    .scl_in_i     (scl_in),
    .scl_low_o    (scl_low),
    .smp_tick_o   (smp_tick),
    .chg_tick_o   (chg_tick)
  );

  localparam int NV = 7;
  localparam logic [1:0]  V_MODE [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd0, 2'd0};
  localparam logic [15:0] V_BAUD [NV] = '{16'd5, 16'd4, 16'd3, 16'd6, 16'd1, 16'd1, 16'd2};
  localparam int          V_LO   [NV] = '{5, 8, 3, 6, 2, 1, 2};
  localparam int          V_HI   [NV] = '{5, 4, 3, 6, 1, 1, 2};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Syncs to a low-phase start, then measures one full period.
  task automatic measure(output int lo, output int hi, output int co, output int so);
    int   guard;
    logic prev;
    logic hit;
    lo = 0; hi = 0; co = -1; so = -1; guard = 0;
    prev = scl_low;
    do begin
      @(negedge clk);
      guard++;
      hit  = !prev && scl_low;
      prev = scl_low;
    end while (!hit && guard < 5000);
    while (scl_low && guard < 5000) begin
      if (chg_tick && co < 0) co = lo;
      lo++; guard++;
      @(negedge clk);
    end
    while (!scl_low && guard < 5000) begin
      if (smp_tick && so < 0) so = hi;
      hi++; guard++;
      @(negedge clk);
    end
  endtask

  task automatic stretch_run(input logic [1:0] m, input int b, input int s, input int h,
                             input string tag);
    int lo, hi, co, so, d0, d1, d2, d3;
    int exp_co;
    @(negedge clk);
    mode = m; baud = 16'(b); setup = 16'(s);
    measure(d0, d1, d2, d3);
    // now at first sample of a low phase
    while (scl_low) @(negedge clk);
    hi = 0; so = -1;
    hold = 1'b1;
    for (int i = 0; i < h; i++) begin
      if (smp_tick && so < 0) so = hi;
      hi++;
      @(negedge clk);
    end
    hold = 1'b0;
    while (!scl_low) begin
      if (smp_tick && so < 0) so = hi;
      hi++;
      @(negedge clk);
    end
    lo = 0; co = -1;
    while (scl_low) begin
      if (chg_tick && co < 0) co = lo;
      lo++;
      @(negedge clk);
    end
    exp_co = (s - b + 2 > 1) ? (s - b + 2) : 1;
    check({"R6 stretched high length ", tag}, hi, b + h);
    check({"R7 sample strobe after stretch ", tag}, so, h + 1);
    check({"R9 change strobe after setup ", tag}, co, exp_co);
    check({"R6 low length after stretch ", tag}, lo, (m == 2'd1) ? 2 * b : b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lo, hi, co, so, cnt;
    string rt;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 drive in reset", int'(scl_low), 0);
    check("R1 strobes in reset", int'(smp_tick | chg_tick), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 drive after reset", int'(scl_low), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode = V_MODE[v]; baud = V_BAUD[v]; setup = '0;
      measure(lo, hi, co, so);
      rt = (V_MODE[v] == 2'd1) ? "R3" : ((V_MODE[v] >= 2'd2) ? "R4" : "R2");
      check($sformatf("%s low length v%0d", rt, v), lo, V_LO[v]);
      check($sformatf("%s high length v%0d", rt, v), hi, V_HI[v]);
      if (V_LO[v] >= 2) check($sformatf("R8 change strobe v%0d", v), co, 1);
      if (V_HI[v] >= 2) check($sformatf("R7 sample strobe v%0d", v), so, 1);
    end

    // R6/R7/R9: stretches
    stretch_run(2'd1, 6, 10, 5, "fast");
    stretch_run(2'd0, 4, 3, 2, "std");

    // R5: zero baud parks the clock
    @(negedge clk);
    mode = 2'd0; baud = 16'd3; setup = '0;
    measure(lo, hi, co, so);
    baud = '0;
    repeat (20) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (scl_low || smp_tick || chg_tick) cnt++;
      @(negedge clk);
    end
    check("R5 parked outputs active cycles", cnt, 0);

    // R10: no start while the line is held low
    hold = 1'b1;
    baud = 16'd3;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (scl_low) cnt++;
    end
    check("R10 drive while line held", cnt, 0);
    hold = 1'b0;
    measure(lo, hi, co, so);
    check("R10 R5 restart low length", lo, 3);
    check("R5 restart high length", hi, 3);

    // R1: reset mid-run
    while (!scl_low) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 drive on mid-run reset", int'(scl_low), 0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule